// File: doc/BRIEF.md
# Dual-Address Two-Wire Port Controller

This block is the serial front end of a sixteen-port expander. It listens on a two-wire (I2C) bus that it oversamples on a system clock. It answers at two 7-bit slave addresses. Group A holds eight mixed I/O and output ports. Group B holds eight output-only ports. The upper three address bits are fixed per group and the lower four come from an external address decoder. The block finds START and STOP conditions, shifts address and data bytes in, drives the acknowledge bit, and shifts read data out with an open-drain style "pull low" output.

Write bytes load the output latch of the addressed group. Read bytes return the port levels captured during the acknowledge bit that comes before each byte. A group A read alternates between port levels and a transition-flag byte. A group B read returns the port levels for every byte. The block gives a neighbouring transition detector two strobes: a sample strobe for each group A port capture and a clear strobe at each group A address acknowledge. An active-low abort input drops any transfer in progress.

Top module: `dual_port_i2c_slave`

## Requirements
- R1: After reset the group A latch equals parameter A_INIT, the group B latch equals B_INIT, and the SDA pull-low output is inactive.
- R2: An address byte whose upper seven bits are {A_PREFIX (default 3'b110), addr_lo_i} selects group A, and one with {B_PREFIX (default 3'b101), addr_lo_i} selects group B. The eighth bit is read (1) or write (0). The slave pulls SDA low during the ninth clock to acknowledge.
- R3: During a write, every data byte the slave acknowledges loads the addressed group's latch. The other group's latch keeps its value, and further bytes keep loading until STOP.
- R4: A group A read returns the port levels first, then the flags_i byte, and keeps alternating between the two for as long as the master acknowledges.
- R5: A group B read returns the group B port levels for every byte.
- R6: The port levels sent in a byte are the ones captured at the rising SCL edge of the acknowledge bit just before that byte. Changes after that edge show up only in the next port byte.
- R7: det_sample_o pulses once for each group A port byte captured. det_clear_o pulses once at the address acknowledge of every group A access. Neither pulses for group B.
- R8: An address matching neither group gets no acknowledge, and the data bytes that follow before the next START neither get an acknowledge nor change a latch.
- R9: After a master NACK on a read byte, the slave does not pull SDA low until the next START or STOP.
- R10: bus_abort_n low abandons the current transfer and releases SDA. Both latches keep their values, and the rest of that transfer is ignored until a new START.
- R11: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START begins a new address phase without a STOP in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_abort_n | input | 1 | Active-low transfer abort |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| addr_lo_i | input | 4 | Low four address bits from the decoder |
| pins_a_i | input | 8 | Group A port levels |
| pins_b_i | input | 8 | Group B port levels |
| flags_i | input | 8 | Transition-flag byte for group A reads |
| out_a_o | output | 8 | Group A output latch |
| out_b_o | output | 8 | Group B output latch |
| det_sample_o | output | 1 | Pulse: group A ports captured |
| det_clear_o | output | 1 | Pulse: group A address acknowledged |

## Verification
The bench changes the port levels right after an acknowledge. A design that samples at the byte boundary, or that keeps sampling while it shifts, would send the new value one byte early. A three-byte group A read checks the port/flag alternation and the number of sample strobes. A design that resets the phase or strobes on flag bytes would send the wrong byte order or count too many pulses. After a NACK the master keeps clocking with no STOP, and a design that keeps shifting would pull SDA low. An abort in the middle of a data byte and an address that matches neither group check that a slave which does not go idle would acknowledge the byte or corrupt a latch.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 7;
   localparam int LO_W   = 4;
   localparam int PFX_W  = ADDR_W - LO_W;
   localparam int CNT_W  = $clog2(BYTE_W + 1);

   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK, ST_IGNORE
   } eng_state_t;
endpackage

// File: rtl/i2cx_line_cond.sv
module i2cx_line_cond #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_c,
   output logic stop_c,
   output logic sda_s
);
   logic [STAGES-1:0] scl_q, sda_q;
   logic              scl_d, sda_d, scl_s;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) begin scl_q[0] <= 1'b1; sda_q[0] <= 1'b1; end
               else        begin scl_q[0] <= scl_i; sda_q[0] <= sda_i; end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) begin scl_q[g] <= 1'b1; sda_q[g] <= 1'b1; end
               else        begin scl_q[g] <= scl_q[g-1]; sda_q[g] <= sda_q[g-1]; end
         end
      end
   endgenerate

   assign scl_s = scl_q[STAGES-1];
   assign sda_s = sda_q[STAGES-1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin scl_d <= 1'b1; sda_d <= 1'b1; end
      else        begin scl_d <= scl_s; sda_d <= sda_s; end

   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;

   AST_COND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_c, stop_c, scl_rise, scl_fall})) else $error("bus events overlap"); // R11
endmodule

// File: rtl/i2cx_out_latch.sv
module i2cx_out_latch #(
   parameter int          W    = 8,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)  q <= INIT;
      else if (wr) q <= d;

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(q)) else $error("latch moved without write"); // R3
endmodule

// File: rtl/i2cx_engine.sv
module i2cx_engine
   import i2cx_pkg::*;
#(
   parameter logic [PFX_W-1:0] A_PREFIX = 3'b110,
   parameter logic [PFX_W-1:0] B_PREFIX = 3'b101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_c,
   input  logic              stop_c,
   input  logic              sda_s,
   input  logic [LO_W-1:0]   addr_lo,
   input  logic [BYTE_W-1:0] pins_a,
   input  logic [BYTE_W-1:0] pins_b,
   input  logic [BYTE_W-1:0] flags,
   output logic              sda_pull,
   output logic              wr_a,
   output logic              wr_b,
   output logic [BYTE_W-1:0] wr_data,
   output logic              det_sample,
   output logic              det_clear
);
   eng_state_t        st;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] sh;
   logic              rw, grp_b, flag_next;

   assign wr_data = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; cnt <= '0; sh <= '0; rw <= 1'b0; grp_b <= 1'b0;
         flag_next <= 1'b0; sda_pull <= 1'b0; wr_a <= 1'b0; wr_b <= 1'b0;
         det_sample <= 1'b0; det_clear <= 1'b0;
      end else begin
         wr_a <= 1'b0; wr_b <= 1'b0; det_sample <= 1'b0; det_clear <= 1'b0;
         if (!abort_n) begin
            st <= ST_IDLE; sda_pull <= 1'b0;
         end else if (start_c) begin
            st <= ST_ADDR; cnt <= '0; sda_pull <= 1'b0;
         end else if (stop_c) begin
            st <= ST_IDLE; sda_pull <= 1'b0;
         end else begin
            unique case (st)
               ST_ADDR, ST_WDATA: begin
                  if (scl_rise) begin
                     sh  <= {sh[BYTE_W-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
                     if (st == ST_WDATA) begin
                        sda_pull <= 1'b1; st <= ST_WACK;
                     end else if (sh[BYTE_W-1:1] == {A_PREFIX, addr_lo} ||
                                  sh[BYTE_W-1:1] == {B_PREFIX, addr_lo}) begin
                        grp_b    <= (sh[BYTE_W-1:1] == {B_PREFIX, addr_lo});
                        rw       <= sh[0];
                        sda_pull <= 1'b1;
                        st       <= ST_AACK;
                     end else begin
                        st <= ST_IGNORE;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_rise) begin
                     det_clear <= ~grp_b;
                     if (rw) begin
                        sh         <= grp_b ? pins_b : pins_a;
                        det_sample <= ~grp_b;
                        flag_next  <= ~grp_b;
                     end
                  end else if (scl_fall) begin
                     cnt      <= '0;
                     st       <= rw ? ST_RDATA : ST_WDATA;
                     sda_pull <= rw ? ~sh[BYTE_W-1] : 1'b0;
                  end
               end
               ST_WACK: begin
                  if (scl_rise) begin
                     wr_a <= ~grp_b; wr_b <= grp_b;
                  end else if (scl_fall) begin
                     sda_pull <= 1'b0; cnt <= '0; st <= ST_WDATA;
                  end
               end
               ST_RDATA: begin
                  if (scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (cnt == CNT_W'(BYTE_W)) begin
                        sda_pull <= 1'b0; st <= ST_RACK;
                     end else begin
                        sh       <= {sh[BYTE_W-2:0], 1'b0};
                        sda_pull <= ~sh[BYTE_W-2];
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     if (sda_s) begin
                        st <= ST_IGNORE;
                     end else if (!grp_b && flag_next) begin
                        sh <= flags; flag_next <= 1'b0;
                     end else begin
                        sh         <= grp_b ? pins_b : pins_a;
                        det_sample <= ~grp_b;
                        flag_next  <= ~grp_b;
                     end
                  end else if (scl_fall) begin
                     cnt <= '0; st <= ST_RDATA; sda_pull <= ~sh[BYTE_W-1];
                  end
               end
               default: sda_pull <= 1'b0;
            endcase
         end
      end
   end

   AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      !abort_n |=> !sda_pull) else $error("SDA held after abort"); // R10
   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_c && abort_n) |=> !sda_pull) else $error("SDA held after STOP"); // R11
   AST_ONE_GROUP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_a, wr_b})) else $error("both groups written"); // R3
   AST_STROBE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (det_sample || det_clear || wr_a || wr_b) |-> $past(scl_rise)) else $error("strobe off SCL rise"); // R6
   AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IGNORE && !start_c) |=> !sda_pull) else $error("SDA driven while ignoring"); // R9
endmodule

// File: rtl/dual_port_i2c_slave.sv
module dual_port_i2c_slave
   import i2cx_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter logic [PFX_W-1:0]  A_PREFIX    = 3'b110,
   parameter logic [PFX_W-1:0]  B_PREFIX    = 3'b101,
   parameter logic [BYTE_W-1:0] A_INIT      = 8'hF0,
   parameter logic [BYTE_W-1:0] B_INIT      = 8'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_abort_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull_o,
   input  logic [LO_W-1:0]   addr_lo_i,
   input  logic [BYTE_W-1:0] pins_a_i,
   input  logic [BYTE_W-1:0] pins_b_i,
   input  logic [BYTE_W-1:0] flags_i,
   output logic [BYTE_W-1:0] out_a_o,
   output logic [BYTE_W-1:0] out_b_o,
   output logic              det_sample_o,
   output logic              det_clear_o
);
   localparam int N_GRP = 2;
   localparam logic [N_GRP*BYTE_W-1:0] INIT_VEC = {B_INIT, A_INIT};

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (A_PREFIX == B_PREFIX) begin : g_bad_prefix
         $error("group prefixes must differ");
      end
   endgenerate

   logic scl_rise, scl_fall, start_c, stop_c, sda_s;
   logic [N_GRP-1:0]        wr_grp;
   logic [BYTE_W-1:0]       wr_data;
   logic [BYTE_W-1:0]       q_grp [N_GRP];

   i2cx_line_cond #(.STAGES(SYNC_STAGES)) u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c),
      .stop_c(stop_c), .sda_s(sda_s));

   i2cx_engine #(.A_PREFIX(A_PREFIX), .B_PREFIX(B_PREFIX)) u_eng (
      .clk(clk), .rst_n(rst_n), .abort_n(bus_abort_n),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c),
      .stop_c(stop_c), .sda_s(sda_s), .addr_lo(addr_lo_i),
      .pins_a(pins_a_i), .pins_b(pins_b_i), .flags(flags_i),
      .sda_pull(sda_pull_o), .wr_a(wr_grp[0]), .wr_b(wr_grp[1]),
      .wr_data(wr_data), .det_sample(det_sample_o), .det_clear(det_clear_o));

   generate
      for (genvar g = 0; g < N_GRP; g++) begin : g_latch
         i2cx_out_latch #(.W(BYTE_W), .INIT(INIT_VEC[g*BYTE_W +: BYTE_W])) u_lat (
            .clk(clk), .rst_n(rst_n), .wr(wr_grp[g]), .d(wr_data), .q(q_grp[g]));
      end
   endgenerate

   assign out_a_o = q_grp[0];
   assign out_b_o = q_grp[1];
endmodule

// File: tb/tb_dual_port_i2c_slave.sv
module tb_dual_port_i2c_slave;
   localparam int Q = 10;
   localparam logic [3:0] LO = 4'hA;
   localparam logic [7:0] AW = {3'b110, LO, 1'b0};
   localparam logic [7:0] AR = {3'b110, LO, 1'b1};
   localparam logic [7:0] BW = {3'b101, LO, 1'b0};
   localparam logic [7:0] BR = {3'b101, LO, 1'b1};

   logic clk = 1'b0, rst_n = 1'b0, abort_n = 1'b1;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic [7:0] pins_a = 8'h00, pins_b = 8'h00, flags = 8'h00;
   logic sda_pull, det_s, det_c, sda_bus;
   logic [7:0] out_a, out_b;
   int total = 0, bad = 0, n_samp = 0, n_clr = 0;

   always #5 clk = ~clk;
   assign sda_bus = sda_m & ~sda_pull;

   dual_port_i2c_slave dut (
      .clk(clk), .rst_n(rst_n), .bus_abort_n(abort_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_pull_o(sda_pull), .addr_lo_i(LO), .pins_a_i(pins_a), .pins_b_i(pins_b),
      .flags_i(flags), .out_a_o(out_a), .out_b_o(out_b),
      .det_sample_o(det_s), .det_clear_o(det_c));

   always @(posedge clk) begin
      if (det_s) n_samp++;
      if (det_c) n_clr++;
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
   endtask
   task automatic bus_stop();
      sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
   endtask
   task automatic clk_bit(input logic b, output logic r);
      sda_m = b; tick(Q); scl_m = 1'b1; tick(Q); r = sda_bus; tick(Q); scl_m = 1'b0; tick(Q);
   endtask
   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
      clk_bit(1'b1, r);
      ack = ~r;
   endtask
   task automatic read_byte(input logic m_ack, output logic [7:0] d);
      logic r;
      for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, r); d[i] = r; end
      clk_bit(~m_ack, r);
   endtask

   task automatic t_reset();
      chk("R1 latch A", out_a, 8'hF0);
      chk("R1 latch B", out_b, 8'h0F);
      chk("R1 sda idle", {7'd0, sda_pull}, 8'h00);
   endtask

   task automatic t_write_a();
      logic ack;
      bus_start(); send_byte(AW, ack); chk("R2 ack A write", {7'd0, ack}, 8'h01);
      send_byte(8'h5A, ack); chk("R3 data ack", {7'd0, ack}, 8'h01);
      bus_stop();
      chk("R3 latch A", out_a, 8'h5A);
      chk("R3 latch B kept", out_b, 8'h0F);
   endtask

   task automatic t_write_b_multi();
      logic ack;
      bus_start(); send_byte(BW, ack); chk("R2 ack B write", {7'd0, ack}, 8'h01);
      send_byte(8'h11, ack); chk("R3 B first", out_b, 8'h11);
      send_byte(8'hEE, ack); chk("R3 B second", out_b, 8'hEE);
      bus_stop();
      chk("R3 latch A kept", out_a, 8'h5A);
   endtask

   task automatic t_bad_addr();
      logic ack;
      bus_start(); send_byte(8'hF4, ack); chk("R8 no addr ack", {7'd0, ack}, 8'h00);
      send_byte(8'h00, ack); chk("R8 no data ack", {7'd0, ack}, 8'h00);
      bus_stop();
      chk("R8 latch A", out_a, 8'h5A);
      chk("R8 latch B", out_b, 8'hEE);
   endtask

   task automatic t_read_a();
      logic ack; logic [7:0] d; int s0, c0;
      pins_a = 8'h3C; flags = 8'hA5; s0 = n_samp; c0 = n_clr;
      bus_start(); send_byte(AR, ack); chk("R2 ack A read", {7'd0, ack}, 8'h01);
      read_byte(1'b1, d); chk("R4 port byte", d, 8'h3C);
      pins_a = 8'hC3;
      read_byte(1'b1, d); chk("R4 flag byte", d, 8'hA5);
      read_byte(1'b0, d); chk("R4 port again", d, 8'hC3);
      chk("R7 sample pulses", 8'(n_samp - s0), 8'd2);
      chk("R7 clear pulses", 8'(n_clr - c0), 8'd1);
      read_byte(1'b0, d); chk("R9 no drive after NACK", d, 8'hFF);
      chk("R9 sda released", {7'd0, sda_pull}, 8'h00);
      bus_stop();
   endtask

   task automatic t_read_b();
      logic ack; logic [7:0] d; int s0, c0;
      pins_b = 8'h81; s0 = n_samp; c0 = n_clr;
      bus_start(); send_byte(BR, ack); chk("R2 ack B read", {7'd0, ack}, 8'h01);
      pins_b = 8'h7E;
      read_byte(1'b1, d); chk("R6 sampled at ack", d, 8'h81);
      read_byte(1'b0, d); chk("R5 pins again", d, 8'h7E);
      bus_stop();
      chk("R7 no B strobes", 8'((n_samp - s0) + (n_clr - c0)), 8'd0);
   endtask

   task automatic t_rstart();
      logic ack; logic r;
      bus_start(); send_byte(AW, ack); send_byte(8'h96, ack);
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
      send_byte(BW, ack); chk("R11 ack after restart", {7'd0, ack}, 8'h01);
      send_byte(8'h69, ack); bus_stop();
      chk("R11 A written", out_a, 8'h96);
      chk("R11 B written", out_b, 8'h69);
      r = 1'b0;
   endtask

   task automatic t_abort();
      logic ack; logic r;
      bus_start(); send_byte(AW, ack);
      for (int i = 0; i < 4; i++) clk_bit(1'b0, r);
      abort_n = 1'b0; tick(3); abort_n = 1'b1;
      for (int i = 0; i < 4; i++) clk_bit(1'b0, r);
      clk_bit(1'b1, r); chk("R10 no ack after abort", {7'd0, r}, 8'h01);
      bus_stop();
      chk("R10 latch A kept", out_a, 8'h96);
      bus_start(); send_byte(AW, ack); send_byte(8'h24, ack); bus_stop();
      chk("R10 next transfer", out_a, 8'h24);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      tick(5); rst_n = 1'b1; tick(5);
      t_reset();
      t_write_a();
      t_write_b_multi();
      t_bad_addr();
      t_read_a();
      t_read_b();
      t_rstart();
      t_abort();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule